// File: doc/BRIEF.md
# Aspect-Configurable Dual-Port RAM

This block holds exactly 2,304 bits of storage. A two-bit shape input switches it at run time between 128 words of 18 bits and 256 words of 9 bits. The storage is built as two 9-bit lanes that share a 7-bit row index. A wide access uses both lanes of a row. A narrow access picks one lane with the lowest bit of the local address. One port only writes and the other only reads, and each has its own clock. A read returns its data one read-clock edge after the read is issued.

Several instances can be combined to build larger memories. To make the word wider, place instances side by side on the same address and join their data buses. To add depth, stack instances. Each one then receives a strap value, and the address bits above the local 8-bit field must match that strap before the instance will accept a write or drive read data. An instance that is not selected returns zeros, so the outputs of a stack can be combined with a plain OR. The same array can serve as ordinary RAM, as ROM filled through the write port, or as the storage behind a FIFO.

Top module: `dpram_aspect`

## Requirements
- R1: The storage is 128 rows of 18 bits (2,304 bits) and is shared by both shapes. In narrow shape, local address 2r reads bits 8:0 and local address 2r+1 reads bits 17:9 of the row that wide shape addresses as r.
- R2: The shape code 2'b01 selects narrow shape (256 x 9). The codes 2'b00, 2'b10 and 2'b11 all select wide shape (128 x 18).
- R3: In wide shape, the row is given by local address bits 6:0. Local address bit 7 has no effect, and all 18 data bits are written and read.
- R4: In narrow shape, local address bits 7:1 give the row and bit 0 picks the lane. A write stores wr_data[8:0] into that lane only and leaves the other lane of the row unchanged. A read returns the lane in rd_data[8:0], with rd_data[17:9] equal to zero.
- R5: rd_data changes only at the read-clock edge where rd_en is sampled high. Before that edge it still shows the previous result.
- R6: While rd_en is low, rd_data holds its value whatever happens to the address or shape inputs.
- R7: When a write and a read hit the same location on the same edge (with both clocks tied together), the read returns the data that was there before the write.
- R8: Address bits above the local 8-bit field must equal blk_id for a write to take effect. A write with any other value leaves the storage unchanged.
- R9: A read whose upper address bits differ from blk_id loads all zeros into rd_data.
- R10: A synchronous reset clears rd_data to zero. It does not change the stored contents.
- R11: A write and a read to different locations on the same edge both complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| rd_clk | input | 1 | Read port clock |
| rst | input | 1 | Synchronous active-high reset of the read result, on rd_clk |
| mode | input | 2 | Shape select: 01 narrow, all other codes wide |
| blk_id | input | SEL_W (2) | Strap value for stacking; compared with the upper address bits |
| wr_en | input | 1 | Write request |
| wr_addr | input | SEL_W+8 (10) | Write address: block select above an 8-bit local address |
| wr_data | input | 18 | Write data; only bits 8:0 are used in narrow shape |
| rd_en | input | 1 | Read request |
| rd_addr | input | SEL_W+8 (10) | Read address: block select above an 8-bit local address |
| rd_data | output | 18 | Read result, registered, zero when the block is not selected |

## Verification
A write is applied at the write-clock edge where it is sampled. It can therefore be seen by a read issued on any later edge. A read result appears at the read-clock edge where rd_en is high and stays until the next sampled read. The bench drives inputs on falling edges and samples rd_data on the following falling edge, which is the first point where the result is due. For the latency requirement it also samples rd_data just before the edge, where the previous value must still be present. Reset, hold, mismatch and same-location cases are each checked on the first falling edge after the edge that produces them.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    localparam int DEF_LANE_W = 9;
    localparam int DEF_ROWS   = 128;
    localparam int DEF_SEL_W  = 2;
    localparam int LANES      = 2;

    typedef enum logic [1:0] {
        SHAPE_WIDE   = 2'b00,
        SHAPE_NARROW = 2'b01,
        SHAPE_RSV_A  = 2'b10,
        SHAPE_RSV_B  = 2'b11
    } shape_e;

    // Only the narrow code selects the 9-bit view; reserved codes act as wide.
    function automatic logic is_narrow(input logic [1:0] code);
        return shape_e'(code) == SHAPE_NARROW;
    endfunction

    // Lane write strobes for one access.
    function automatic logic [LANES-1:0] lane_strobe(input logic narrow, input logic lane);
        if (!narrow) return '1;
        return lane ? LANES'(2'b10) : LANES'(2'b01);
    endfunction

endpackage

// File: rtl/dpram_addr_map.sv
module dpram_addr_map
    import dpram_pkg::*;
#(
    parameter int ROW_AW = 7,
    parameter int SEL_W  = 2,
    localparam int LOC_AW = ROW_AW + 1,
    localparam int AW     = LOC_AW + SEL_W
) (
    input  logic [1:0]        mode,
    input  logic [AW-1:0]     addr,
    input  logic [SEL_W-1:0]  blk_id,
    output logic [ROW_AW-1:0] row,
    output logic              lane,
    output logic              narrow,
    output logic              hit
);

    logic [LOC_AW-1:0] loc;

    always_comb begin
        loc    = addr[LOC_AW-1:0];
        narrow = is_narrow(mode);
        row    = narrow ? loc[LOC_AW-1:1] : loc[ROW_AW-1:0];
        lane   = narrow & loc[0];
        hit    = (addr[AW-1:LOC_AW] == blk_id);
    end

endmodule

// File: rtl/dpram_core.sv
module dpram_core
    import dpram_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int ROWS   = 128,
    localparam int ROW_AW = $clog2(ROWS),
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              wr_clk,
    input  logic [LANES-1:0]  lane_we,
    input  logic [ROW_AW-1:0] wr_row,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_clk,
    input  logic              rd_stb,
    input  logic [ROW_AW-1:0] rd_row,
    output logic [WORD_W-1:0] rd_word
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [ROWS];
        logic [LANE_W-1:0] q;

        always_ff @(posedge wr_clk) begin
            if (lane_we[g]) bank[wr_row] <= wr_word[g*LANE_W +: LANE_W];
        end

        // Non-blocking update gives old data on a same-edge collision.
        always_ff @(posedge rd_clk) begin
            if (rd_stb) q <= bank[rd_row];
        end

        assign rd_word[g*LANE_W +: LANE_W] = q;
    end

endmodule

// File: rtl/dpram_rd_fmt.sv
module dpram_rd_fmt
    import dpram_pkg::*;
#(
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              hit,
    input  logic              lane,
    input  logic              narrow,
    input  logic [WORD_W-1:0] row_word,
    output logic [WORD_W-1:0] dout
);

    logic hit_q, lane_q, narrow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q    <= 1'b0;
            lane_q   <= 1'b0;
            narrow_q <= 1'b0;
        end else if (en) begin
            hit_q    <= hit;
            lane_q   <= lane;
            narrow_q <= narrow;
        end
    end

    always_comb begin
        if (!hit_q)
            dout = '0;
        else if (narrow_q)
            dout = {{(WORD_W-LANE_W){1'b0}},
                    lane_q ? row_word[WORD_W-1:LANE_W] : row_word[LANE_W-1:0]};
        else
            dout = row_word;
    end

endmodule

// File: rtl/dpram_aspect.sv
module dpram_aspect
    import dpram_pkg::*;
#(
    parameter int LANE_W = DEF_LANE_W,
    parameter int ROWS   = DEF_ROWS,
    parameter int SEL_W  = DEF_SEL_W,
    localparam int WORD_W = LANES * LANE_W,
    localparam int ROW_AW = $clog2(ROWS),
    localparam int AW     = ROW_AW + 1 + SEL_W
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic [SEL_W-1:0]  blk_id,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [ROW_AW-1:0] w_row, r_row;
    logic              w_lane, w_narrow, w_hit;
    logic              r_lane, r_narrow, r_hit;
    logic [LANES-1:0]  lane_we;
    logic [WORD_W-1:0] w_word, raw_row;

    dpram_addr_map #(.ROW_AW(ROW_AW), .SEL_W(SEL_W)) u_wmap (
        .mode(mode), .addr(wr_addr), .blk_id(blk_id),
        .row(w_row), .lane(w_lane), .narrow(w_narrow), .hit(w_hit)
    );

    dpram_addr_map #(.ROW_AW(ROW_AW), .SEL_W(SEL_W)) u_rmap (
        .mode(mode), .addr(rd_addr), .blk_id(blk_id),
        .row(r_row), .lane(r_lane), .narrow(r_narrow), .hit(r_hit)
    );

    always_comb begin
        lane_we = (wr_en && w_hit) ? lane_strobe(w_narrow, w_lane) : '0;
        // Narrow data is copied into both lanes; the strobe picks one.
        w_word  = w_narrow ? {LANES{wr_data[LANE_W-1:0]}} : wr_data;
    end

    dpram_core #(.LANE_W(LANE_W), .ROWS(ROWS)) u_core (
        .wr_clk(wr_clk), .lane_we(lane_we), .wr_row(w_row), .wr_word(w_word),
        .rd_clk(rd_clk), .rd_stb(rd_en), .rd_row(r_row), .rd_word(raw_row)
    );

    dpram_rd_fmt #(.LANE_W(LANE_W)) u_fmt (
        .clk(rd_clk), .rst(rst), .en(rd_en), .hit(r_hit), .lane(r_lane),
        .narrow(r_narrow), .row_word(raw_row), .dout(rd_data)
    );

endmodule

// File: rtl/dpram_aspect_chk.sv
module dpram_aspect_chk #(
    parameter int LANE_W = 9,
    parameter int ROWS   = 128,
    parameter int SEL_W  = 2,
    localparam int WORD_W = 2 * LANE_W,
    localparam int LOC_AW = $clog2(ROWS) + 1,
    localparam int AW     = LOC_AW + SEL_W
) (
    input logic              rd_clk,
    input logic              rst,
    input logic [1:0]        mode,
    input logic [SEL_W-1:0]  blk_id,
    input logic              rd_en,
    input logic [AW-1:0]     rd_addr,
    input logic [WORD_W-1:0] rd_data
);

    logic rst_d;
    always_ff @(posedge rd_clk) rst_d <= rst;

    always @(posedge rd_clk) begin
        if (rst_d) AST_RESET_CLEARS: assert (rd_data == '0); // R10
    end

    AST_MISS_READS_ZERO: assert property (@(posedge rd_clk) disable iff (rst)
        rd_en && (rd_addr[AW-1:LOC_AW] != blk_id) |=> rd_data == '0); // R9

    AST_NARROW_TOP_ZERO: assert property (@(posedge rd_clk) disable iff (rst)
        rd_en && (mode == 2'b01) |=> rd_data[WORD_W-1:LANE_W] == '0); // R4

    AST_IDLE_HOLDS: assert property (@(posedge rd_clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R6

endmodule

bind dpram_aspect dpram_aspect_chk #(.LANE_W(LANE_W), .ROWS(ROWS), .SEL_W(SEL_W)) u_chk (
    .rd_clk(rd_clk), .rst(rst), .mode(mode), .blk_id(blk_id),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sim_dpram_aspect.sv
`timescale 1ns/1ps
module sim_dpram_aspect;

    localparam int SW  = 2;
    localparam int WW  = 18;
    localparam int AW  = SW + 8;
    localparam int NV  = 8;
    localparam logic [SW-1:0] MY_ID = 2'b10;

    // {shape code, local address, data}
    localparam logic [27:0] VEC [NV] = '{
        {2'b00, 8'h05, 18'h2A5A5},
        {2'b01, 8'h0A, 18'h3FFC3},
        {2'b01, 8'h0B, 18'h000F0},
        {2'b10, 8'h85, 18'h13579},
        {2'b11, 8'h7F, 18'h3FFFF},
        {2'b01, 8'hFE, 18'h00155},
        {2'b00, 8'h00, 18'h00001},
        {2'b01, 8'h01, 18'h001AA}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1;
    logic [1:0]    mode = 2'b00;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [WW-1:0] wr_data = '0;
    logic [WW-1:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [WW-1:0] ref_mem [128];

    dpram_aspect u0 (
        .wr_clk(clk), .rd_clk(clk), .rst(rst), .mode(mode), .blk_id(MY_ID),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [WW-1:0] ref_read(input logic [1:0] m, input logic [7:0] a);
        if (m == 2'b01)
            return a[0] ? {9'b0, ref_mem[a[7:1]][17:9]} : {9'b0, ref_mem[a[7:1]][8:0]};
        return ref_mem[a[6:0]];
    endfunction

    task automatic ref_write(input logic [1:0] m, input logic [7:0] a, input logic [WW-1:0] d);
        if (m == 2'b01) begin
            if (a[0]) ref_mem[a[7:1]][17:9] = d[8:0];
            else      ref_mem[a[7:1]][8:0]  = d[8:0];
        end else begin
            ref_mem[a[6:0]] = d;
        end
    endtask

    task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic [AW-1:0] wa, input logic [WW-1:0] wd,
                       input logic re, input logic [AW-1:0] ra);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset state", rd_data, '0);
        rst = 1'b0;

        // Table walk: write, read back at once against the reference.
        for (int i = 0; i < NV; i++) begin
            mode = VEC[i][27:26];
            cyc(1'b1, {MY_ID, VEC[i][25:18]}, VEC[i][17:0], 1'b0, '0);
            ref_write(VEC[i][27:26], VEC[i][25:18], VEC[i][17:0]);
            cyc(1'b0, '0, '0, 1'b1, {MY_ID, VEC[i][25:18]});
            check("R2 R3 R4 table readback", rd_data, ref_read(VEC[i][27:26], VEC[i][25:18]));
        end
        // Second pass after all overwrites.
        for (int i = 0; i < NV; i++) begin
            mode = VEC[i][27:26];
            cyc(1'b0, '0, '0, 1'b1, {MY_ID, VEC[i][25:18]});
            check("R2 R4 table second pass", rd_data, ref_read(VEC[i][27:26], VEC[i][25:18]));
        end

        // R3: bit 7 ignored in wide shape.
        mode = 2'b00;
        cyc(1'b0, '0, '0, 1'b1, {MY_ID, 8'h85});
        check("R3 bit7 ignored", rd_data, ref_mem[5]);

        // R1: wide write seen as two narrow lanes.
        cyc(1'b1, {MY_ID, 8'h09}, 18'h21234, 1'b0, '0);
        ref_write(2'b00, 8'h09, 18'h21234);
        mode = 2'b01;
        cyc(1'b0, '0, '0, 1'b1, {MY_ID, 8'h12});
        check("R1 lower lane", rd_data, {9'b0, 9'h034});
        cyc(1'b0, '0, '0, 1'b1, {MY_ID, 8'h13});
        check("R1 upper lane", rd_data, {9'b0, 9'h109});

        // R7: same location, same edge returns old data.
        mode = 2'b00;
        cyc(1'b1, {MY_ID, 8'h14}, 18'h0BEEF, 1'b0, '0);
        cyc(1'b1, {MY_ID, 8'h14}, 18'h31337, 1'b1, {MY_ID, 8'h14});
        check("R7 collision old data", rd_data, 18'h0BEEF);
        cyc(1'b0, '0, '0, 1'b1, {MY_ID, 8'h14});
        check("R7 new data after", rd_data, 18'h31337);
        ref_write(2'b00, 8'h14, 18'h31337);

        // R11: different locations on one edge.
        cyc(1'b1, {MY_ID, 8'h1E}, 18'h2468A, 1'b1, {MY_ID, 8'h05});
        check("R11 concurrent read", rd_data, ref_mem[5]);
        cyc(1'b0, '0, '0, 1'b1, {MY_ID, 8'h1E});
        check("R11 concurrent write", rd_data, 18'h2468A);

        // R8: write to another block id is dropped.
        cyc(1'b1, {MY_ID, 8'h28}, 18'h11111, 1'b0, '0);
        cyc(1'b1, {2'b01, 8'h28}, 18'h3FFFF, 1'b0, '0);
        cyc(1'b0, '0, '0, 1'b1, {MY_ID, 8'h28});
        check("R8 foreign write ignored", rd_data, 18'h11111);

        // R9: foreign read gives zeros.
        cyc(1'b0, '0, '0, 1'b1, {2'b00, 8'h28});
        check("R9 foreign read zero", rd_data, '0);

        // R6: hold while idle.
        cyc(1'b0, '0, '0, 1'b1, {MY_ID, 8'h28});
        mode = 2'b01;
        cyc(1'b0, '0, '0, 1'b0, {MY_ID, 8'h05});
        check("R6 hold while idle", rd_data, 18'h11111);
        mode = 2'b00;

        // R5: value changes only at the sampled edge.
        @(negedge clk);
        rd_en = 1'b1; rd_addr = {MY_ID, 8'h14};
        #1;
        check("R5 before edge", rd_data, 18'h11111);
        @(negedge clk);
        rd_en = 1'b0;
        check("R5 after edge", rd_data, 18'h31337);

        // R10: reset clears the output but not the storage.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 reset clears output", rd_data, '0);
        cyc(1'b0, '0, '0, 1'b1, {MY_ID, 8'h28});
        check("R10 storage kept", rd_data, 18'h11111);

        finish_run();
    end

endmodule